// File: doc/BRIEF.md
# Dual-Port RAM with Asymmetric Port Widths

This block is a synchronous memory with two ports, A and B, that share one storage array. Each port has an enable, a write enable, an address, write data and read data. The two data widths may differ by a power of two, up to a factor of 32 in either direction. Each port addresses the storage at its own width: a port with width W sees TOTAL_BITS/W words. On the wider port, narrow word `w*R+i` sits in bits `[i*N +: N]` of wide word `w`, where R is the width ratio and N is the narrow width.

Parameters set each port independently:
- Access mode: read/write, read-only or write-only.
- Write behaviour: the read output either holds during a write or shows the written data.
- Polarity of the port enable and of both output resets.
- An optional output register, with a clock enable and a choice of reset priority.

Every read passes through a first output stage, the read latch, which has its own synchronous reset. A single block-wide parameter selects whether all storage and output stages act on the rising or the falling edge of `clk`. When both ports write overlapping bits on the same edge, port A's data is stored.

Top module: `dpram_asym`

## Requirements
- R1: Port widths must be related by 2^n with 0 <= n <= 5. Narrow word `w*R+i` is bits `[i*N +: N]` of wide word `w`, where R is the ratio and N is the narrow width.
- R2: Each port's address selects one of TOTAL_BITS/width words. Data written by either port is read back by both ports at their own widths.
- R3: A read-only port ignores its write enable. Memory is not changed, and an enabled access is performed as a read.
- R4: In no-change mode, an enabled write leaves that port's read latch holding its previous value.
- R5: In write-first mode, after an enabled write the port's read latch holds the data just written.
- R6: Read data appears after one active edge without the output register. With the output register enabled and its clock enable high, it appears after two active edges.
- R7: With reset priority, an asserted output-register reset clears the register at the next active edge, whatever the clock enable is.
- R8: With enable priority, an asserted output-register reset clears the register only when the clock enable is high. Otherwise the register holds.
- R9: An asserted read-latch reset clears the latch to zero at the next active edge and overrides any read or write-first update.
- R10: The port enable and both resets act on their configured level. With active-low selected, a 0 enables the port or asserts the reset.
- R11: With falling-edge operation selected, memory and output stages update only on falling edges of `clk`.
- R12: When both ports write overlapping bits on the same edge, the stored bits are port A's data.
- R13: A disabled port neither writes the memory nor changes its read latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| en_a | input | 1 | Port A enable (polarity set by parameter) |
| we_a | input | 1 | Port A write enable |
| addr_a | input | AW_A | Port A word address |
| wdata_a | input | WIDTH_A | Port A write data |
| lrst_a | input | 1 | Port A read-latch synchronous reset |
| orst_a | input | 1 | Port A output-register synchronous reset |
| oce_a | input | 1 | Port A output-register clock enable |
| rdata_a | output | WIDTH_A | Port A read data |
| en_b | input | 1 | Port B enable (polarity set by parameter) |
| we_b | input | 1 | Port B write enable |
| addr_b | input | AW_B | Port B word address |
| wdata_b | input | WIDTH_B | Port B write data |
| lrst_b | input | 1 | Port B read-latch synchronous reset |
| orst_b | input | 1 | Port B output-register synchronous reset |
| oce_b | input | 1 | Port B output-register clock enable |
| rdata_b | output | WIDTH_B | Port B read data |

## Verification
The hardest case to reach is a same-edge write collision where the narrow port's word lies inside the wide port's word. Random addresses seldom hit it, so a directed step has both ports write such an overlapping pair on one edge. Both ports then read the location back, which shows the narrow slice carrying A's data and the rest carrying B's.

A second instance uses active-low controls, falling-edge operation, enable priority and a read-only port. On that instance, an output-register reset is held with the clock enable low to show the register holding. The read-only port is driven with its write enable high to show that the memory does not change.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        PM_RW = 2'd0,
        PM_RO = 2'd1,
        PM_WO = 2'd2
    } port_mode_e;

    typedef enum logic {
        WM_NO_CHANGE   = 1'b0,
        WM_WRITE_FIRST = 1'b1
    } wr_mode_e;

    typedef enum logic {
        RP_RESET_FIRST = 1'b0,
        RP_CE_FIRST    = 1'b1
    } rst_pri_e;

    // Port controls after polarity and mode decoding, all active-high.
    typedef struct packed {
        logic we;
        logic rd;
        logic echo;
        logic lrst;
        logic orst;
    } port_ctl_t;

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Widths must differ by a power of two no larger than 32.
    function automatic bit ratio_ok(input int wa, input int wb);
        int hi;
        int lo;
        int r;
        hi = imax(wa, wb);
        lo = imin(wa, wb);
        if (lo < 1 || (hi % lo) != 0) return 1'b0;
        r = hi / lo;
        return ((r & (r - 1)) == 0) && (r <= 32);
    endfunction

endpackage

// File: rtl/dpram_ctl.sv
module dpram_ctl
    import dpram_pkg::*;
#(
    parameter port_mode_e MODE      = PM_RW,
    parameter wr_mode_e   WMODE     = WM_NO_CHANGE,
    parameter bit         EN_HIGH   = 1'b1,
    parameter bit         LRST_HIGH = 1'b1,
    parameter bit         ORST_HIGH = 1'b1
) (
    input  logic      en,
    input  logic      we,
    input  logic      lrst,
    input  logic      orst,
    output port_ctl_t ctl
);

    logic act;
    assign act = EN_HIGH ? en : ~en;

    always_comb begin
        ctl.we   = act && we && (MODE != PM_RO);
        ctl.rd   = act && ((MODE == PM_RO) || ((MODE == PM_RW) && !we));
        ctl.echo = act && we && (MODE == PM_RW) && (WMODE == WM_WRITE_FIRST);
        ctl.lrst = LRST_HIGH ? lrst : ~lrst;
        ctl.orst = ORST_HIGH ? orst : ~orst;
    end

endmodule

// File: rtl/dpram_outpipe.sv
module dpram_outpipe
    import dpram_pkg::*;
#(
    parameter int       W       = 8,
    parameter wr_mode_e WMODE   = WM_NO_CHANGE,
    parameter bit       OUT_REG = 1'b0,
    parameter rst_pri_e RPRI    = RP_RESET_FIRST
) (
    input  logic          ck,
    input  port_ctl_t     ctl,
    input  logic [W-1:0]  rd_word,
    input  logic [W-1:0]  wr_word,
    input  logic          oce,
    output logic [W-1:0]  dout
);

    logic [W-1:0] latch_q;

    always_ff @(posedge ck) begin
        if (ctl.lrst)      latch_q <= '0;
        else if (ctl.rd)   latch_q <= rd_word;
        else if (ctl.echo) latch_q <= wr_word;
    end

    p_latch_rst_r9: assert property (@(posedge ck) disable iff (ctl.orst)
        ctl.lrst |=> (latch_q == '0));

    // Covers R13 as well: no read and no echo leaves the latch untouched.
    p_hold_r4: assert property (@(posedge ck) disable iff (ctl.orst)
        (!ctl.lrst && !ctl.rd && !ctl.echo) |=> $stable(latch_q));

    p_echo_r5: assert property (@(posedge ck) disable iff (ctl.orst)
        (!ctl.lrst && ctl.echo && (WMODE == WM_WRITE_FIRST)) |=> (latch_q == $past(wr_word)));

    generate
        if (OUT_REG) begin : g_reg
            logic [W-1:0] reg_q;

            always_ff @(posedge ck) begin
                if (ctl.orst && ((RPRI == RP_RESET_FIRST) || oce)) reg_q <= '0;
                else if (oce)                                     reg_q <= latch_q;
            end

            assign dout = reg_q;

            p_pipe_r6: assert property (@(posedge ck) disable iff (ctl.lrst)
                (!ctl.orst && oce) |=> (reg_q == $past(latch_q)));

            if (RPRI == RP_RESET_FIRST) begin : g_rf
                p_rst_first_r7: assert property (@(posedge ck) disable iff (ctl.lrst)
                    ctl.orst |=> (reg_q == '0));
            end else begin : g_cf
                p_ce_first_r8: assert property (@(posedge ck) disable iff (ctl.lrst)
                    (ctl.orst && !oce) |=> $stable(reg_q));
            end
        end else begin : g_noreg
            logic unused_ok;
            assign unused_ok = ^{oce, ctl.orst};
            assign dout = latch_q;
        end
    endgenerate

endmodule

// File: rtl/dpram_asym.sv
module dpram_asym
    import dpram_pkg::*;
#(
    parameter int         TOTAL_BITS  = 512,
    parameter int         WIDTH_A     = 8,
    parameter int         WIDTH_B     = 32,
    parameter port_mode_e MODE_A      = PM_RW,
    parameter port_mode_e MODE_B      = PM_RW,
    parameter wr_mode_e   WMODE_A     = WM_NO_CHANGE,
    parameter wr_mode_e   WMODE_B     = WM_WRITE_FIRST,
    parameter bit         OREG_A      = 1'b0,
    parameter bit         OREG_B      = 1'b1,
    parameter rst_pri_e   RPRI_A      = RP_RESET_FIRST,
    parameter rst_pri_e   RPRI_B      = RP_RESET_FIRST,
    parameter bit         EN_HIGH_A   = 1'b1,
    parameter bit         EN_HIGH_B   = 1'b1,
    parameter bit         LRST_HIGH_A = 1'b1,
    parameter bit         LRST_HIGH_B = 1'b1,
    parameter bit         ORST_HIGH_A = 1'b1,
    parameter bit         ORST_HIGH_B = 1'b1,
    parameter bit         FALL_EDGE   = 1'b0,
    localparam int        AW_A        = $clog2(TOTAL_BITS / WIDTH_A),
    localparam int        AW_B        = $clog2(TOTAL_BITS / WIDTH_B)
) (
    input  logic               clk,
    input  logic               en_a,
    input  logic               we_a,
    input  logic [AW_A-1:0]    addr_a,
    input  logic [WIDTH_A-1:0] wdata_a,
    input  logic               lrst_a,
    input  logic               orst_a,
    input  logic               oce_a,
    output logic [WIDTH_A-1:0] rdata_a,
    input  logic               en_b,
    input  logic               we_b,
    input  logic [AW_B-1:0]    addr_b,
    input  logic [WIDTH_B-1:0] wdata_b,
    input  logic               lrst_b,
    input  logic               orst_b,
    input  logic               oce_b,
    output logic [WIDTH_B-1:0] rdata_b
);

    localparam int NW     = imin(WIDTH_A, WIDTH_B);
    localparam int NWORDS = TOTAL_BITS / NW;
    localparam int IW     = $clog2(NWORDS);
    localparam int RA     = WIDTH_A / NW;
    localparam int RB     = WIDTH_B / NW;

    generate
        if (!ratio_ok(WIDTH_A, WIDTH_B) || (TOTAL_BITS % imax(WIDTH_A, WIDTH_B)) != 0) begin : g_bad_cfg
            $error("dpram_asym: width ratio or total size not supported");
        end
    endgenerate

    logic ck;
    assign ck = FALL_EDGE ? ~clk : clk;

    port_ctl_t ctl_a;
    port_ctl_t ctl_b;

    dpram_ctl #(
        .MODE(MODE_A), .WMODE(WMODE_A), .EN_HIGH(EN_HIGH_A),
        .LRST_HIGH(LRST_HIGH_A), .ORST_HIGH(ORST_HIGH_A)
    ) u_ctl_a (
        .en(en_a), .we(we_a), .lrst(lrst_a), .orst(orst_a), .ctl(ctl_a)
    );

    dpram_ctl #(
        .MODE(MODE_B), .WMODE(WMODE_B), .EN_HIGH(EN_HIGH_B),
        .LRST_HIGH(LRST_HIGH_B), .ORST_HIGH(ORST_HIGH_B)
    ) u_ctl_b (
        .en(en_b), .we(we_b), .lrst(lrst_b), .orst(orst_b), .ctl(ctl_b)
    );

    function automatic logic [IW-1:0] idx_a(input logic [AW_A-1:0] a, input int i);
        return IW'(int'(a) * RA + i);
    endfunction

    function automatic logic [IW-1:0] idx_b(input logic [AW_B-1:0] a, input int i);
        return IW'(int'(a) * RB + i);
    endfunction

    logic [NW-1:0] mem [NWORDS];

    // Port B is written first so that port A's slices overwrite on overlap.
    always_ff @(posedge ck) begin
        if (ctl_b.we) begin
            for (int i = 0; i < RB; i++) mem[idx_b(addr_b, i)] <= wdata_b[i*NW +: NW];
        end
        if (ctl_a.we) begin
            for (int i = 0; i < RA; i++) mem[idx_a(addr_a, i)] <= wdata_a[i*NW +: NW];
        end
    end

    logic [WIDTH_A-1:0] rd_a;
    logic [WIDTH_B-1:0] rd_b;

    always_comb begin
        for (int i = 0; i < RA; i++) rd_a[i*NW +: NW] = mem[idx_a(addr_a, i)];
        for (int i = 0; i < RB; i++) rd_b[i*NW +: NW] = mem[idx_b(addr_b, i)];
    end

    dpram_outpipe #(
        .W(WIDTH_A), .WMODE(WMODE_A), .OUT_REG(OREG_A), .RPRI(RPRI_A)
    ) u_out_a (
        .ck(ck), .ctl(ctl_a), .rd_word(rd_a), .wr_word(wdata_a),
        .oce(oce_a), .dout(rdata_a)
    );

    dpram_outpipe #(
        .W(WIDTH_B), .WMODE(WMODE_B), .OUT_REG(OREG_B), .RPRI(RPRI_B)
    ) u_out_b (
        .ck(ck), .ctl(ctl_b), .rd_word(rd_b), .wr_word(wdata_b),
        .oce(oce_b), .dout(rdata_b)
    );

    p_ro_no_write_r3: assert property (@(posedge ck) disable iff (ctl_a.lrst || ctl_b.lrst)
        ((MODE_A == PM_RO) || (MODE_B == PM_RO)) |-> !((MODE_A == PM_RO) && ctl_a.we) && !((MODE_B == PM_RO) && ctl_b.we));

endmodule

// File: tb/sim_dpram_asym.sv
`timescale 1ns/1ps
module sim_dpram_asym;
    import dpram_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // ---------------- instance u0: A 8-bit no-change, B 32-bit write-first + reg, rising
    logic        ena0 = 0, wea0 = 0, lra0 = 0;
    logic [5:0]  aa0 = 0;
    logic [7:0]  da0 = 0;
    logic        enb0 = 0, web0 = 0, lrb0 = 0, orb0 = 0, oceb0 = 0;
    logic [3:0]  ab0 = 0;
    logic [31:0] db0 = 0;
    logic [7:0]  ra0;
    logic [31:0] rb0;

    dpram_asym #(
        .TOTAL_BITS(512), .WIDTH_A(8), .WIDTH_B(32),
        .MODE_A(PM_RW), .MODE_B(PM_RW),
        .WMODE_A(WM_NO_CHANGE), .WMODE_B(WM_WRITE_FIRST),
        .OREG_A(1'b0), .OREG_B(1'b1),
        .RPRI_A(RP_RESET_FIRST), .RPRI_B(RP_RESET_FIRST),
        .FALL_EDGE(1'b0)
    ) u0 (
        .clk(clk),
        .en_a(ena0), .we_a(wea0), .addr_a(aa0), .wdata_a(da0),
        .lrst_a(lra0), .orst_a(1'b0), .oce_a(1'b0), .rdata_a(ra0),
        .en_b(enb0), .we_b(web0), .addr_b(ab0), .wdata_b(db0),
        .lrst_b(lrb0), .orst_b(orb0), .oce_b(oceb0), .rdata_b(rb0)
    );

    // ---------------- instance u1: A 16-bit write-first + reg (CE priority), B 4-bit read-only,
    // active-low enables and resets, falling edge
    logic        ena1_n = 1, wea1 = 0, lra1_n = 1, ora1_n = 1, ocea1 = 0;
    logic [3:0]  aa1 = 0;
    logic [15:0] da1 = 0;
    logic        enb1_n = 1, web1 = 0, lrb1_n = 1;
    logic [5:0]  ab1 = 0;
    logic [3:0]  db1 = 0;
    logic [15:0] ra1;
    logic [3:0]  rb1;

    dpram_asym #(
        .TOTAL_BITS(256), .WIDTH_A(16), .WIDTH_B(4),
        .MODE_A(PM_RW), .MODE_B(PM_RO),
        .WMODE_A(WM_WRITE_FIRST), .WMODE_B(WM_NO_CHANGE),
        .OREG_A(1'b1), .OREG_B(1'b0),
        .RPRI_A(RP_CE_FIRST), .RPRI_B(RP_RESET_FIRST),
        .EN_HIGH_A(1'b0), .EN_HIGH_B(1'b0),
        .LRST_HIGH_A(1'b0), .LRST_HIGH_B(1'b0),
        .ORST_HIGH_A(1'b0), .ORST_HIGH_B(1'b0),
        .FALL_EDGE(1'b1)
    ) u1 (
        .clk(clk),
        .en_a(ena1_n), .we_a(wea1), .addr_a(aa1), .wdata_a(da1),
        .lrst_a(lra1_n), .orst_a(ora1_n), .oce_a(ocea1), .rdata_a(ra1),
        .en_b(enb1_n), .we_b(web1), .addr_b(ab1), .wdata_b(db1),
        .lrst_b(lrb1_n), .orst_b(1'b1), .oce_b(1'b0), .rdata_b(rb1)
    );

    // ---------------- reference state
    logic [511:0] m0 = '0;
    logic [7:0]   la0 = '0;
    logic [31:0]  lb0 = '0, qb0 = '0;
    logic [255:0] m1 = '0;
    logic [15:0]  la1 = '0, qa1 = '0;
    logic [3:0]   lb1 = '0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // One rising-edge cycle of u0; entered and left just after a falling edge.
    task automatic cyc0(input string tag);
        logic [511:0] nm;
        logic [7:0]   nla;
        logic [31:0]  nlb, nqb;
        nla = la0;
        if (lra0) nla = '0;
        else if (ena0 && !wea0) nla = m0[int'(aa0)*8 +: 8];
        nlb = lb0;
        if (lrb0) nlb = '0;
        else if (enb0) nlb = web0 ? db0 : m0[int'(ab0)*32 +: 32];
        nqb = qb0;
        if (orb0) nqb = '0;
        else if (oceb0) nqb = lb0;
        nm = m0;
        if (enb0 && web0) nm[int'(ab0)*32 +: 32] = db0;
        if (ena0 && wea0) nm[int'(aa0)*8 +: 8] = da0;
        @(posedge clk);
        m0 = nm; la0 = nla; lb0 = nlb; qb0 = nqb;
        @(negedge clk);
        chk({tag, " portA"}, {24'h0, ra0}, {24'h0, la0});
        chk({tag, " portB"}, rb0, qb0);
    endtask

    // One falling-edge cycle of u1; entered and left just after a rising edge.
    task automatic cyc1(input string tag);
        logic [255:0] nm;
        logic [15:0]  nla, nqa;
        logic [3:0]   nlb;
        nla = la1;
        if (!lra1_n) nla = '0;
        else if (!ena1_n) nla = wea1 ? da1 : m1[int'(aa1)*16 +: 16];
        nqa = qa1;
        if (!ora1_n && ocea1) nqa = '0;
        else if (ocea1) nqa = la1;
        nlb = lb1;
        if (!lrb1_n) nlb = '0;
        else if (!enb1_n) nlb = m1[int'(ab1)*4 +: 4];
        nm = m1;
        if (!ena1_n && wea1) nm[int'(aa1)*16 +: 16] = da1;
        @(negedge clk);
        m1 = nm; la1 = nla; qa1 = nqa; lb1 = nlb;
        @(posedge clk);
        chk({tag, " portA"}, {16'h0, ra1}, {16'h0, qa1});
        chk({tag, " portB"}, {28'h0, rb1}, {28'h0, lb1});
    endtask

    bit done = 0;

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) got=timeout exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);

        // ---- u0: reset state (R9)
        lra0 = 1; lrb0 = 1; orb0 = 1; oceb0 = 1;
        cyc0("R9 reset"); cyc0("R9 reset");
        lra0 = 0; lrb0 = 0; orb0 = 0;

        // ---- u0: fill through wide write-first port (R5)
        enb0 = 1; web0 = 1;
        for (int w = 0; w < 16; w++) begin
            ab0 = 4'(w); db0 = $urandom;
            cyc0("R5 write-first");
        end
        enb0 = 0; web0 = 0;
        cyc0("R6 drain");

        // ---- u0: narrow reads of every word, checks lane mapping (R1)
        ena0 = 1; wea0 = 0;
        for (int k = 0; k < 64; k++) begin
            aa0 = 6'(k);
            cyc0("R1 mapping");
        end

        // ---- u0: no-change write holds latch, then read back (R4)
        wea0 = 1; aa0 = 6'd5; da0 = 8'hA7;
        cyc0("R4 no-change");
        wea0 = 0;
        cyc0("R4 readback");
        ena0 = 0;

        // ---- u0: wide read latency with output register (R6)
        enb0 = 1; web0 = 0; ab0 = 4'd1; oceb0 = 1;
        cyc0("R6 latency");
        enb0 = 0;
        cyc0("R6 latency"); cyc0("R6 latency");

        // ---- u0: output reg reset wins over low clock enable (R7)
        orb0 = 1; oceb0 = 0;
        cyc0("R7 reset-first");
        orb0 = 0; oceb0 = 1;

        // ---- u0: same-edge overlapping writes, A wins (R12)
        ena0 = 1; wea0 = 1; aa0 = 6'd9; da0 = 8'h3C;
        enb0 = 1; web0 = 1; ab0 = 4'd2; db0 = 32'hDEAD_BEEF;
        cyc0("R12 collision");
        wea0 = 0; web0 = 0;
        cyc0("R12 collision read");
        enb0 = 0; ena0 = 0;
        cyc0("R12 collision read"); cyc0("R12 collision read");

        // ---- u0: disabled ports write nothing (R13)
        wea0 = 1; web0 = 1; da0 = 8'h11; db0 = 32'h2222_3333; aa0 = 6'd9; ab0 = 4'd2;
        cyc0("R13 disabled"); cyc0("R13 disabled");
        wea0 = 0; web0 = 0; ena0 = 1; enb0 = 1;
        cyc0("R13 verify");
        ena0 = 0; enb0 = 0;
        cyc0("R13 verify"); cyc0("R13 verify");

        // ---- u0: constrained random (R2)
        for (int n = 0; n < 400; n++) begin
            ena0 = $urandom_range(0, 1); wea0 = $urandom_range(0, 1);
            aa0 = 6'($urandom); da0 = 8'($urandom);
            enb0 = $urandom_range(0, 1); web0 = ($urandom_range(0, 3) == 0);
            ab0 = 4'($urandom); db0 = $urandom;
            lra0 = ($urandom_range(0, 15) == 0); lrb0 = ($urandom_range(0, 15) == 0);
            orb0 = ($urandom_range(0, 15) == 0); oceb0 = $urandom_range(0, 1);
            cyc0("R2 random");
        end
        ena0 = 0; enb0 = 0; lra0 = 0; lrb0 = 0; orb0 = 0;

        // ---- u1: align to just after a rising edge
        @(posedge clk);

        // active-low resets (R10)
        lra1_n = 0; lrb1_n = 0; ora1_n = 0; ocea1 = 1;
        cyc1("R10 active-low reset"); cyc1("R10 active-low reset");
        lra1_n = 1; lrb1_n = 1; ora1_n = 1;

        // fill through wide port on falling edges (R11)
        ena1_n = 0; wea1 = 1;
        for (int w = 0; w < 16; w++) begin
            aa1 = 4'(w); da1 = 16'($urandom);
            cyc1("R11 falling-edge write");
        end
        ena1_n = 1; wea1 = 0;
        enb1_n = 0;
        for (int k = 0; k < 64; k++) begin
            ab1 = 6'(k);
            cyc1("R11 falling-edge read");
        end

        // read-only port ignores its write enable (R3)
        ab1 = 6'd7; web1 = 1; db1 = 4'hF ^ m1[28 +: 4];
        cyc1("R3 read-only");
        enb1_n = 1; web1 = 0;
        ena1_n = 0; aa1 = 4'd1;
        cyc1("R3 read-only verify"); 
        ena1_n = 1;
        cyc1("R3 read-only verify"); cyc1("R3 read-only verify");

        // enable-priority reset (R8)
        ora1_n = 0; ocea1 = 0;
        cyc1("R8 ce-first hold"); cyc1("R8 ce-first hold");
        ocea1 = 1;
        cyc1("R8 ce-first clear");
        ora1_n = 1;

        // random on u1 (R6, R10)
        for (int n = 0; n < 400; n++) begin
            ena1_n = $urandom_range(0, 1); wea1 = ($urandom_range(0, 2) == 0);
            aa1 = 4'($urandom); da1 = 16'($urandom);
            enb1_n = $urandom_range(0, 1); web1 = $urandom_range(0, 1);
            ab1 = 6'($urandom); db1 = 4'($urandom);
            lra1_n = ($urandom_range(0, 15) != 0); lrb1_n = ($urandom_range(0, 15) != 0);
            ora1_n = ($urandom_range(0, 15) != 0); ocea1 = $urandom_range(0, 1);
            cyc1("R6 R10 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule